// File: doc/BRIEF.md
# Handshaked Byte Transfer Engine

This block moves single bytes between a host and a device over a shift-register port. Pacing comes from three active-low control lines instead of a shift clock. The host drives a transfer-in-progress line and a transfer-acknowledge line. The device answers on a transfer-request line. While the host holds transfer-in-progress low, every change of the {acknowledge, in-progress} pair is one step. In the host-to-device direction, a step appends the current shift-register byte to a 16-entry outgoing buffer. In the device-to-host direction, a step places the next pending byte of a 128-entry incoming buffer into the shift register.

Each step raises a one-cycle shift event. The interrupt logic around the block turns that event into a flag. When the host releases transfer-in-progress, the block reports the collected outgoing packet with its length. It then asserts transfer-request if incoming bytes are still waiting.

While no transfer is running, the block stays in a sync mode. In that mode the request line copies every change of the acknowledge line. A separate agent fills the incoming buffer through a write port and then starts it with a load strobe. That agent also reads the outgoing buffer through a read port.

The engine compares each handshake level against its value from the previous cycle. A level change seen at a clock edge takes effect at that same edge.

Top module: `hs_byte_xfer`

## Requirements
- R1: After reset, req_n_o is 1. sr_evt_o and pkt_valid_o are 0, sr_q_o is 0 and both buffers count as empty.
- R2: While tip_n_i is 0, one step happens in each cycle where {ack_n_i, tip_n_i} differs from its value in the previous cycle. The falling edge of tip_n_i is itself such a change.
- R3: With dir_h2d_i = 1, a step writes sr_q_o into the outgoing buffer at the current count and increments the count. sr_evt_o pulses for one cycle after that edge. Outgoing entry k is read one cycle after out_raddr_i = k.
- R4: Once 16 bytes are stored, further host-to-device steps store nothing and give no sr_evt_o pulse. The count stays at 16.
- R5: With dir_h2d_i = 0 and bytes pending, a step loads the next incoming byte into sr_q_o and pulses sr_evt_o.
- R6: The step that loads the last pending byte also drives req_n_o to 1.
- R7: A device-to-host step with no pending bytes leaves sr_q_o unchanged and gives no sr_evt_o pulse.
- R8: If tip_n_i is 1 in both the current and the previous cycle, a change of ack_n_i sets req_n_o to the new ack_n_i level and pulses sr_evt_o.
- R9: In the cycle after tip_n_i rises, sr_evt_o always pulses. pkt_valid_o pulses with pkt_len_o equal to the stored count, but only if that count is nonzero. The count then restarts at 0.
- R10: If incoming bytes are still pending when tip_n_i rises, req_n_o goes to 0 at that edge.
- R11: in_load_i with length in_len_i restarts the read index at entry 0 and pulses sr_evt_o. It leaves req_n_o unchanged.
- R12: sr_wr_i loads sr_wdata_i into sr_q_o at the next edge, provided no step happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_n_i | input | 1 | Host transfer-acknowledge, active low |
| tip_n_i | input | 1 | Host transfer-in-progress, active low |
| dir_h2d_i | input | 1 | Shift direction: 1 = host to device |
| sr_wr_i | input | 1 | Host write strobe for the shift register |
| sr_wdata_i | input | 8 | Host write data for the shift register |
| sr_q_o | output | 8 | Shift register contents |
| req_n_o | output | 1 | Device transfer-request, active low |
| sr_evt_o | output | 1 | One-cycle shift event |
| pkt_valid_o | output | 1 | Outgoing packet complete pulse |
| pkt_len_o | output | 5 | Byte count of the completed packet |
| out_raddr_i | input | 4 | Outgoing buffer read address |
| out_rdata_o | output | 8 | Outgoing buffer read data, one cycle latency |
| in_we_i | input | 1 | Incoming buffer write enable |
| in_waddr_i | input | 7 | Incoming buffer write address |
| in_wdata_i | input | 8 | Incoming buffer write data |
| in_load_i | input | 1 | Start a new incoming packet |
| in_len_i | input | 8 | Length of the new incoming packet |

## Verification
The hardest case to reach is the moment tip_n_i rises while an incoming packet is still pending. That takes three things in order:
- an open host-to-device transfer,
- an incoming packet loaded while the transfer is still open,
- the transfer then closed.

Only then do the request assertion and the packet pulse with length 1 show up together. The bench follows exactly this order. It then reverses the direction and drains the pending bytes with acknowledge toggles until the request line lets go.

Buffer overflow is reached with twenty steps inside one transfer. Idle sync is reached by toggling acknowledge only after in-progress has been high for two cycles.

// File: rtl/hs_byte_xfer_pkg.sv
package hs_byte_xfer_pkg;
  // What the handshake lines ask for in the current cycle
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_STEP = 2'd1,
    ACT_SYNC = 2'd2,
    ACT_END  = 2'd3
  } hs_act_e;
endpackage

// File: rtl/hbx_hs_track.sv
module hbx_hs_track
  import hs_byte_xfer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ack_n,
  input  logic    tip_n,
  output logic    ack_q,
  output logic    tip_q,
  output hs_act_e act
);
  // Previous levels, sampled every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b1;
      tip_q <= 1'b1;
    end else begin
      ack_q <= ack_n;
      tip_q <= tip_n;
    end
  end

  always_comb begin
    act = ACT_NONE;
    if (!tip_n) begin
      if ((ack_n != ack_q) || (tip_n != tip_q)) act = ACT_STEP;
    end else if (!tip_q) begin
      act = ACT_END;
    end else if (ack_n != ack_q) begin
      act = ACT_SYNC;
    end
  end
endmodule

// File: rtl/hbx_ram.sv
module hbx_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hs_byte_xfer.sv
module hs_byte_xfer
  import hs_byte_xfer_pkg::*;
#(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  parameter int DW        = 8,
  localparam int OAW = $clog2(OUT_DEPTH),
  localparam int IAW = $clog2(IN_DEPTH),
  localparam int OCW = $clog2(OUT_DEPTH + 1),
  localparam int ICW = $clog2(IN_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ack_n_i,
  input  logic           tip_n_i,
  input  logic           dir_h2d_i,
  input  logic           sr_wr_i,
  input  logic [DW-1:0]  sr_wdata_i,
  output logic [DW-1:0]  sr_q_o,
  output logic           req_n_o,
  output logic           sr_evt_o,
  output logic           pkt_valid_o,
  output logic [OCW-1:0] pkt_len_o,
  input  logic [OAW-1:0] out_raddr_i,
  output logic [DW-1:0]  out_rdata_o,
  input  logic           in_we_i,
  input  logic [IAW-1:0] in_waddr_i,
  input  logic [DW-1:0]  in_wdata_i,
  input  logic           in_load_i,
  input  logic [ICW-1:0] in_len_i
);
  hs_act_e        act;
  logic           ack_q, tip_q;
  logic [OCW-1:0] out_cnt_q;
  logic [ICW-1:0] in_idx_q, in_size_q, in_idx_nxt;
  logic [DW-1:0]  in_pre;
  logic           step_h2d, step_d2h, last_byte;

  hbx_hs_track u_track (
    .clk   (clk),
    .rst   (rst),
    .ack_n (ack_n_i),
    .tip_n (tip_n_i),
    .ack_q (ack_q),
    .tip_q (tip_q),
    .act   (act)
  );

  assign step_h2d  = (act == ACT_STEP) && dir_h2d_i && (out_cnt_q < OCW'(OUT_DEPTH));
  assign step_d2h  = (act == ACT_STEP) && !dir_h2d_i && (in_idx_q < in_size_q);
  assign last_byte = ({1'b0, in_idx_q} + 1'b1) >= {1'b0, in_size_q};

  always_comb begin
    in_idx_nxt = in_idx_q;
    if (in_load_i)     in_idx_nxt = '0;
    else if (step_d2h) in_idx_nxt = in_idx_q + 1'b1;
  end

  hbx_ram #(.DEPTH(OUT_DEPTH), .W(DW)) u_out_ram (
    .clk   (clk),
    .we    (step_h2d),
    .waddr (out_cnt_q[OAW-1:0]),
    .wdata (sr_q_o),
    .raddr (out_raddr_i),
    .rdata (out_rdata_o)
  );

  // Prefetch: in_pre always holds the byte at the current read index
  hbx_ram #(.DEPTH(IN_DEPTH), .W(DW)) u_in_ram (
    .clk   (clk),
    .we    (in_we_i),
    .waddr (in_waddr_i),
    .wdata (in_wdata_i),
    .raddr (in_idx_nxt[IAW-1:0]),
    .rdata (in_pre)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q_o      <= '0;
      req_n_o     <= 1'b1;
      sr_evt_o    <= 1'b0;
      pkt_valid_o <= 1'b0;
      pkt_len_o   <= '0;
      out_cnt_q   <= '0;
      in_idx_q    <= '0;
      in_size_q   <= '0;
    end else begin
      sr_evt_o    <= 1'b0;
      pkt_valid_o <= 1'b0;
      in_idx_q    <= in_idx_nxt;
      if (in_load_i) begin
        in_size_q <= in_len_i;
        sr_evt_o  <= 1'b1;
      end
      if (sr_wr_i) sr_q_o <= sr_wdata_i;
      case (act)
        ACT_STEP: begin
          if (step_h2d) begin
            out_cnt_q <= out_cnt_q + 1'b1;
            sr_evt_o  <= 1'b1;
          end
          if (step_d2h) begin
            sr_q_o   <= in_pre;
            sr_evt_o <= 1'b1;
            if (last_byte) req_n_o <= 1'b1;
          end
        end
        ACT_SYNC: begin
          req_n_o  <= ack_n_i;
          sr_evt_o <= 1'b1;
        end
        ACT_END: begin
          sr_evt_o    <= 1'b1;
          pkt_valid_o <= (out_cnt_q != '0);
          pkt_len_o   <= out_cnt_q;
          out_cnt_q   <= '0;
          if (in_idx_q < in_size_q) req_n_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hs_byte_xfer_chk.sv
module hs_byte_xfer_chk #(
  parameter int OUT_DEPTH = 16,
  parameter int OCW       = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           ack_n_i,
  input logic           tip_n_i,
  input logic           dir_h2d_i,
  input logic           in_load_i,
  input logic           ack_q,
  input logic           tip_q,
  input logic [OCW-1:0] out_cnt_q,
  input logic           req_n_o,
  input logic           sr_evt_o,
  input logic           pkt_valid_o,
  input logic [OCW-1:0] pkt_len_o
);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    out_cnt_q <= OCW'(OUT_DEPTH));

  p_full_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!tip_n_i && ((ack_n_i != ack_q) || !tip_q) && dir_h2d_i &&
     (out_cnt_q == OCW'(OUT_DEPTH)) && !in_load_i) |=> !sr_evt_o);

  p_sync_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (tip_n_i && tip_q && (ack_n_i != ack_q)) |=>
      (sr_evt_o && (req_n_o == $past(ack_n_i))));

  p_end_event_r9: assert property (@(posedge clk) disable iff (rst)
    (tip_n_i && !tip_q) |=> sr_evt_o);

  p_pkt_len_r9: assert property (@(posedge clk) disable iff (rst)
    pkt_valid_o |-> (pkt_len_o != '0));

  p_load_req_r11: assert property (@(posedge clk) disable iff (rst)
    (in_load_i && tip_n_i && tip_q && (ack_n_i == ack_q)) |=>
      ($stable(req_n_o) && sr_evt_o));
endmodule

bind hs_byte_xfer hs_byte_xfer_chk #(.OUT_DEPTH(OUT_DEPTH), .OCW(OCW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ack_n_i     (ack_n_i),
  .tip_n_i     (tip_n_i),
  .dir_h2d_i   (dir_h2d_i),
  .in_load_i   (in_load_i),
  .ack_q       (ack_q),
  .tip_q       (tip_q),
  .out_cnt_q   (out_cnt_q),
  .req_n_o     (req_n_o),
  .sr_evt_o    (sr_evt_o),
  .pkt_valid_o (pkt_valid_o),
  .pkt_len_o   (pkt_len_o)
);

// File: tb/hs_byte_xfer_tb.sv
`timescale 1ns/1ps
module hs_byte_xfer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ack_n = 1'b1, tip_n = 1'b1, dir = 1'b1;
  logic       sr_wr = 1'b0;
  logic [7:0] sr_wdata = '0;
  logic [7:0] sr_q;
  logic       req_n, evt, pkt_v;
  logic [4:0] pkt_len;
  logic [3:0] out_raddr = '0;
  logic [7:0] out_rdata;
  logic       in_we = 1'b0;
  logic [6:0] in_waddr = '0;
  logic [7:0] in_wdata = '0;
  logic       in_load = 1'b0;
  logic [7:0] in_len = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  hs_byte_xfer u_dut (
    .clk(clk), .rst(rst), .ack_n_i(ack_n), .tip_n_i(tip_n), .dir_h2d_i(dir),
    .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata), .sr_q_o(sr_q), .req_n_o(req_n),
    .sr_evt_o(evt), .pkt_valid_o(pkt_v), .pkt_len_o(pkt_len),
    .out_raddr_i(out_raddr), .out_rdata_o(out_rdata),
    .in_we_i(in_we), .in_waddr_i(in_waddr), .in_wdata_i(in_wdata),
    .in_load_i(in_load), .in_len_i(in_len)
  );

  // {ack_n, tip_n, sr_wr, sr_data[8], exp_evt, exp_pkt, exp_len[5]}
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b1, 8'hA1, 1'b0, 1'b0, 5'd0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 5'd0},
    {1'b1, 1'b0, 1'b1, 8'hA2, 1'b0, 1'b0, 5'd0},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 5'd0},
    {1'b0, 1'b0, 1'b1, 8'hA3, 1'b0, 1'b0, 5'd0},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 5'd0},
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 5'd3},
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 5'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Advance one clock and settle 2 ns after the edge
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int evts;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk("R1 req_n", req_n, 1);
    chk("R1 evt", evt, 0);
    chk("R1 pkt", pkt_v, 0);
    chk("R1 sr", sr_q, 0);

    // Table: host-to-device packet of three bytes (R2 R3 R9 R12)
    for (int i = 0; i < 8; i++) begin
      ack_n = VEC[i][17]; tip_n = VEC[i][16];
      sr_wr = VEC[i][15]; sr_wdata = VEC[i][14:7];
      cyc();
      sr_wr = 1'b0;
      chk($sformatf("R2 R3 evt row%0d", i), evt, VEC[i][6]);
      chk($sformatf("R9 pkt row%0d", i), pkt_v, VEC[i][5]);
      if (VEC[i][5]) chk($sformatf("R9 len row%0d", i), pkt_len, VEC[i][4:0]);
    end
    chk("R12 sr write", sr_q, 8'hA3);
    for (int k = 0; k < 3; k++) begin
      out_raddr = 4'(k);
      cyc();
      chk($sformatf("R3 outbuf[%0d]", k), out_rdata, 8'hA1 + k);
    end

    // Overflow: twenty steps, only sixteen stored (R4)
    sr_wr = 1'b1; sr_wdata = 8'h5C;
    cyc();
    sr_wr = 1'b0;
    evts = 0;
    tip_n = 1'b0;
    cyc();
    evts += int'(evt);
    for (int s = 0; s < 19; s++) begin
      ack_n = ~ack_n;
      cyc();
      evts += int'(evt);
    end
    chk("R4 step events", evts, 16);
    tip_n = 1'b1;
    cyc();
    chk("R4 R9 pkt", pkt_v, 1);
    chk("R4 R9 len", pkt_len, 16);
    out_raddr = 4'd15;
    cyc();
    chk("R4 outbuf[15]", out_rdata, 8'h5C);

    // Fill the incoming buffer
    for (int k = 0; k < 3; k++) begin
      in_we = 1'b1; in_waddr = 7'(k); in_wdata = 8'hB0 + 8'(k);
      cyc();
    end
    in_we = 1'b0;

    // Load during an open transfer, then close it (R11 R10)
    dir = 1'b1; tip_n = 1'b0;
    cyc();
    chk("R2 tip fall step", evt, 1);
    in_load = 1'b1; in_len = 8'd3;
    cyc();
    in_load = 1'b0;
    chk("R11 load evt", evt, 1);
    chk("R11 req unchanged", req_n, 1);
    tip_n = 1'b1;
    cyc();
    chk("R10 req asserted", req_n, 0);
    chk("R9 end evt", evt, 1);
    chk("R9 pkt len1", pkt_len, 1);
    chk("R9 pkt one", pkt_v, 1);

    // Device-to-host drain (R5 R6 R7)
    dir = 1'b0; tip_n = 1'b0;
    cyc();
    chk("R5 byte0", sr_q, 8'hB0);
    chk("R5 evt0", evt, 1);
    chk("R5 req still low", req_n, 0);
    ack_n = ~ack_n;
    cyc();
    chk("R5 byte1", sr_q, 8'hB1);
    chk("R5 req low1", req_n, 0);
    ack_n = ~ack_n;
    cyc();
    chk("R6 byte2", sr_q, 8'hB2);
    chk("R6 req released", req_n, 1);
    ack_n = ~ack_n;
    cyc();
    chk("R7 no evt", evt, 0);
    chk("R7 sr kept", sr_q, 8'hB2);
    tip_n = 1'b1;
    cyc();
    chk("R9 empty end evt", evt, 1);
    chk("R9 empty no pkt", pkt_v, 0);
    chk("R10 nothing pending", req_n, 1);

    // Idle sync (R8)
    cyc();
    ack_n = 1'b0;
    cyc();
    chk("R8 req follows low", req_n, 0);
    chk("R8 evt low", evt, 1);
    ack_n = 1'b1;
    cyc();
    chk("R8 req follows high", req_n, 1);
    chk("R8 evt high", evt, 1);
    cyc();
    chk("R8 idle quiet", evt, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule